// File: doc/BRIEF.md
# Speculative Branch History with Checkpoint Repair

This block holds one global branch-direction history register per hardware thread. The front end updates a thread's history when it predicts a conditional branch: the predicted direction is shifted in at bit 0. A downstream indirect-target predictor reads the current history and combines it with the branch address to index its tables. Before each update, the block saves the old history in a per-thread checkpoint ring together with the branch's sequence number.

The back end repairs the history through three ports:
- **Commit** retires the oldest checkpoint of a thread and leaves the history alone.
- **Squash** at sequence number N discards every checkpoint younger than N. The history returns to the snapshot of the oldest discarded branch.
- **Resolve** reports a direction misprediction. The history becomes that branch's snapshot shifted left by one, with the actual outcome at bit 0. Younger checkpoints are discarded.

A thread that holds as many outstanding checkpoints as its ring has entries refuses new predictions through its ready bit.

Top module: `spec_hist_ckpt`

## Requirements
- R1: After reset every thread's history is zero, every checkpoint ring is empty and every bit of pred_ready is 1.
- R2: An accepted predict to thread T sets T's history, one cycle later, to {old[HIST_LEN-2:0], pred_taken}, and stores the old history with pred_seq as the youngest checkpoint.
- R3: pred_ready[T] is 0 exactly when thread T holds DEPTH (default 16) checkpoints. A predict to T while pred_ready[T] is 0 changes neither the history nor the ring.
- R4: A commit to thread T frees T's oldest checkpoint and leaves the history unchanged. A commit to a thread with no checkpoints is ignored.
- R5: A squash with sequence N to thread T finds the oldest checkpoint of T whose sequence number is greater than N. The history becomes that checkpoint's value, and that checkpoint and all younger ones are freed. If no such checkpoint exists, nothing changes.
- R6: A resolve with sequence S and outcome D to thread T finds the checkpoint of T whose sequence number equals S. The history becomes {checkpoint[HIST_LEN-2:0], D}, that checkpoint is kept, and all younger ones are freed. If no checkpoint has sequence S, nothing changes.
- R7: Operations addressed to one thread never change another thread's history or ring.
- R8: When a squash or resolve reaches thread T in a cycle, any predict or commit to T in the same cycle is ignored, and a squash takes precedence over a resolve.
- R9: hist_flat carries thread t's history at bits [t*HIST_LEN +: HIST_LEN], driven straight from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Predicted branch present |
| pred_tid | input | TID_W | Thread of the predicted branch |
| pred_seq | input | SEQ_W | Sequence number of the predicted branch |
| pred_taken | input | 1 | Predicted direction |
| pred_ready | output | NUM_THREADS | Per-thread room for a new checkpoint |
| commit_valid | input | 1 | Retire the oldest checkpoint |
| commit_tid | input | TID_W | Thread to retire from |
| squash_valid | input | 1 | Wrong-path squash |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Branches with larger sequence numbers are squashed |
| resolve_valid | input | 1 | Direction misprediction report |
| resolve_tid | input | TID_W | Thread of the mispredicted branch |
| resolve_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| resolve_taken | input | 1 | Actual direction |
| hist_flat | output | NUM_THREADS*HIST_LEN | All thread histories |

## Verification
Every history change is due exactly one clock edge after the operation that causes it, because the history sits in a single register behind the port. pred_ready is a function of the ring occupancy, so it too moves one edge after an accepted predict, commit, squash or resolve.

The bench drives each operation after a falling edge and lets the design capture it on the next rising edge. At that same rising edge it advances a behavioural model built on plain arrays. At the following falling edge it compares both thread histories and both ready bits with the model. As a result, every check lands in the first cycle where the result is due, and never sooner.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int unsigned SHC_MAX_HIST = 64;

  // Speculative update: shift left one place, new direction at bit 0.
  // Callers truncate the result to their own history length.
  function automatic logic [SHC_MAX_HIST-1:0] shc_shift(
    input logic [SHC_MAX_HIST-1:0] h,
    input logic                    dir
  );
    return {h[SHC_MAX_HIST-2:0], dir};
  endfunction
endpackage

// File: rtl/shc_ckpt_buf.sv
module shc_ckpt_buf #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned SEQ_W    = 16,
  parameter int unsigned HIST_LEN = 16
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(DEPTH)-1:0]     wr_idx,
  input  logic [SEQ_W-1:0]             wr_seq,
  input  logic [HIST_LEN-1:0]          wr_ck,
  input  logic [$clog2(DEPTH)-1:0]     head,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [SEQ_W-1:0]             key,
  input  logic                         match_eq,
  output logic                         hit,
  output logic [$clog2(DEPTH+1)-1:0]   hit_pos,
  output logic [HIST_LEN-1:0]          hit_ck
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [SEQ_W-1:0]    seq_q [DEPTH];
  logic [HIST_LEN-1:0] ck_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      seq_q[wr_idx] <= wr_seq;
      ck_q[wr_idx]  <= wr_ck;
    end
  end

  // Walk from oldest to youngest; the first live entry that matches wins.
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    hit_ck  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      logic             cond;
      idx  = head + PTR_W'(i);
      cond = match_eq ? (seq_q[idx] == key) : (seq_q[idx] > key);
      if (!hit && (CNT_W'(i) < count) && cond) begin
        hit     = 1'b1;
        hit_pos = CNT_W'(i);
        hit_ck  = ck_q[idx];
      end
    end
  end
endmodule

// File: rtl/shc_thread_lane.sv
module shc_thread_lane
  import shc_pkg::*;
#(
  parameter int unsigned HIST_LEN = 16,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned SEQ_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pred_fire,
  input  logic [SEQ_W-1:0]    pred_seq,
  input  logic                pred_taken,
  input  logic                commit_fire,
  input  logic                squash_fire,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                resolve_fire,
  input  logic [SEQ_W-1:0]    resolve_seq,
  input  logic                resolve_taken,
  output logic [HIST_LEN-1:0] hist,
  output logic                ready
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [HIST_LEN-1:0] hist_q;
  logic [PTR_W-1:0]    head_q;
  logic [CNT_W-1:0]    count_q;

  // Named events for the assertions.
  logic repair, ev_push, ev_pop, sq_hit, rs_hit;
  logic hit;
  logic [CNT_W-1:0]    hit_pos;
  logic [HIST_LEN-1:0] hit_ck;
  logic [PTR_W-1:0]    tail_idx;

  assign ready    = (count_q != CNT_W'(DEPTH));
  assign repair   = squash_fire | resolve_fire;
  assign ev_push  = pred_fire & ready & ~repair;
  assign ev_pop   = commit_fire & (count_q != '0) & ~repair;
  assign tail_idx = head_q + PTR_W'(count_q);
  assign sq_hit   = squash_fire & hit;
  assign rs_hit   = resolve_fire & ~squash_fire & hit;

  shc_ckpt_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .HIST_LEN(HIST_LEN)) u_buf (
    .clk      (clk),
    .wr_en    (ev_push),
    .wr_idx   (tail_idx),
    .wr_seq   (pred_seq),
    .wr_ck    (hist_q),
    .head     (head_q),
    .count    (count_q),
    .key      (squash_fire ? squash_seq : resolve_seq),
    .match_eq (~squash_fire),
    .hit      (hit),
    .hit_pos  (hit_pos),
    .hit_ck   (hit_ck)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      head_q  <= '0;
      count_q <= '0;
    end else if (sq_hit) begin
      hist_q  <= hit_ck;
      count_q <= hit_pos;
    end else if (rs_hit) begin
      hist_q  <= HIST_LEN'(shc_shift(SHC_MAX_HIST'(hit_ck), resolve_taken));
      count_q <= hit_pos + CNT_W'(1);
    end else if (!repair) begin
      if (ev_push)
        hist_q <= HIST_LEN'(shc_shift(SHC_MAX_HIST'(hist_q), pred_taken));
      head_q  <= head_q + PTR_W'(ev_pop);
      count_q <= count_q + CNT_W'(ev_push) - CNT_W'(ev_pop);
    end
  end

  assign hist = hist_q;

  assert_push_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> hist_q == HIST_LEN'(shc_shift(SHC_MAX_HIST'($past(hist_q)), $past(pred_taken))));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_fire && !ready && !repair) |=> $stable(hist_q));

  assert_commit_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_push) |=> $stable(hist_q));

  assert_squash_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_hit |=> hist_q == $past(hit_ck));

  assert_resolve_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |=> hist_q[0] == $past(resolve_taken));

  assert_repair_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (repair && !hit) |=> $stable(hist_q) && $stable(count_q));
endmodule

// File: rtl/spec_hist_ckpt.sv
module spec_hist_ckpt #(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned HIST_LEN    = 16,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SEQ_W       = 16,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pred_valid,
  input  logic [TID_W-1:0]                pred_tid,
  input  logic [SEQ_W-1:0]                pred_seq,
  input  logic                            pred_taken,
  output logic [NUM_THREADS-1:0]          pred_ready,
  input  logic                            commit_valid,
  input  logic [TID_W-1:0]                commit_tid,
  input  logic                            squash_valid,
  input  logic [TID_W-1:0]                squash_tid,
  input  logic [SEQ_W-1:0]                squash_seq,
  input  logic                            resolve_valid,
  input  logic [TID_W-1:0]                resolve_tid,
  input  logic [SEQ_W-1:0]                resolve_seq,
  input  logic                            resolve_taken,
  output logic [NUM_THREADS*HIST_LEN-1:0] hist_flat
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    logic [HIST_LEN-1:0] lane_hist;
    logic                lane_ready;

    shc_thread_lane #(.HIST_LEN(HIST_LEN), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .pred_fire     (pred_valid && (pred_tid == TID_W'(t))),
      .pred_seq      (pred_seq),
      .pred_taken    (pred_taken),
      .commit_fire   (commit_valid && (commit_tid == TID_W'(t))),
      .squash_fire   (squash_valid && (squash_tid == TID_W'(t))),
      .squash_seq    (squash_seq),
      .resolve_fire  (resolve_valid && (resolve_tid == TID_W'(t))),
      .resolve_seq   (resolve_seq),
      .resolve_taken (resolve_taken),
      .hist          (lane_hist),
      .ready         (lane_ready)
    );

    assign hist_flat[t*HIST_LEN +: HIST_LEN] = lane_hist;
    assign pred_ready[t] = lane_ready;
  end
endmodule

// File: tb/spec_hist_ckpt_test.sv
module spec_hist_ckpt_test;
  localparam int NT = 2;
  localparam int HL = 16;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic pred_valid = 0, pred_tid = 0, pred_taken = 0;
  logic [15:0] pred_seq = 0;
  logic commit_valid = 0, commit_tid = 0;
  logic squash_valid = 0, squash_tid = 0;
  logic [15:0] squash_seq = 0;
  logic resolve_valid = 0, resolve_tid = 0, resolve_taken = 0;
  logic [15:0] resolve_seq = 0;
  logic [NT-1:0] pred_ready;
  logic [NT*HL-1:0] hist_flat;

  spec_hist_ckpt uut (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_tid(pred_tid), .pred_seq(pred_seq),
    .pred_taken(pred_taken), .pred_ready(pred_ready),
    .commit_valid(commit_valid), .commit_tid(commit_tid),
    .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
    .resolve_valid(resolve_valid), .resolve_tid(resolve_tid),
    .resolve_seq(resolve_seq), .resolve_taken(resolve_taken),
    .hist_flat(hist_flat)
  );

  int checks = 0, fails = 0;
  int seqc = 10;
  int last_seq;
  logic [HL-1:0] mh [NT];
  int mseq [NT][DP];
  logic [HL-1:0] mck [NT][DP];
  int mcnt [NT];

  task automatic clr();
    pred_valid = 0; commit_valid = 0; squash_valid = 0; resolve_valid = 0;
  endtask

  task automatic model_thread(input int t);
    int f;
    if (squash_valid && squash_tid == t[0]) begin
      f = -1;
      for (int i = 0; i < mcnt[t]; i++)
        if (f < 0 && mseq[t][i] > int'(squash_seq)) f = i;
      if (f >= 0) begin mh[t] = mck[t][f]; mcnt[t] = f; end
    end else if (resolve_valid && resolve_tid == t[0]) begin
      f = -1;
      for (int i = 0; i < mcnt[t]; i++)
        if (f < 0 && mseq[t][i] == int'(resolve_seq)) f = i;
      if (f >= 0) begin mh[t] = {mck[t][f][HL-2:0], resolve_taken}; mcnt[t] = f + 1; end
    end else begin
      bit can_push;
      can_push = pred_valid && pred_tid == t[0] && mcnt[t] < DP;
      if (commit_valid && commit_tid == t[0] && mcnt[t] > 0) begin
        for (int i = 0; i < DP - 1; i++) begin
          mseq[t][i] = mseq[t][i+1]; mck[t][i] = mck[t][i+1];
        end
        mcnt[t]--;
      end
      if (can_push) begin
        mseq[t][mcnt[t]] = int'(pred_seq);
        mck[t][mcnt[t]]  = mh[t];
        mcnt[t]++;
        mh[t] = {mh[t][HL-2:0], pred_taken};
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int t = 0; t < NT; t++) begin
      checks++;
      if (hist_flat[t*HL +: HL] !== mh[t]) begin
        fails++;
        $display("FAIL %s thread %0d history actual %h expected %h", tag, t, hist_flat[t*HL +: HL], mh[t]);
      end
      checks++;
      if (pred_ready[t] !== (mcnt[t] < DP)) begin
        fails++;
        $display("FAIL %s thread %0d ready actual %b expected %b", tag, t, pred_ready[t], mcnt[t] < DP);
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    for (int t = 0; t < NT; t++) model_thread(t);
    @(negedge clk);
    compare(tag);
    clr();
  endtask

  task automatic do_pred(input int t, input bit tk, input string tag);
    pred_valid = 1; pred_tid = t[0]; pred_taken = tk; pred_seq = 16'(seqc);
    last_seq = seqc; seqc++;
    step(tag);
  endtask
  task automatic do_commit(input int t, input string tag);
    commit_valid = 1; commit_tid = t[0]; step(tag);
  endtask
  task automatic do_squash(input int t, input int n, input string tag);
    squash_valid = 1; squash_tid = t[0]; squash_seq = 16'(n); step(tag);
  endtask
  task automatic do_resolve(input int t, input int s, input bit tk, input string tag);
    resolve_valid = 1; resolve_tid = t[0]; resolve_seq = 16'(s); resolve_taken = tk; step(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s_a, s_b, s_c;
    logic [15:0] lfsr;
    for (int t = 0; t < NT; t++) begin mh[t] = '0; mcnt[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R2: several predicted patterns on thread 0
    do_pred(0, 1, "R2"); s_a = last_seq;
    do_pred(0, 0, "R2"); s_b = last_seq;
    do_pred(0, 1, "R2"); s_c = last_seq;
    do_pred(0, 1, "R2");
    // R7: thread 1 runs beside thread 0
    do_pred(1, 1, "R7");
    do_pred(1, 1, "R7");
    // R4: commit oldest, history unchanged
    do_commit(0, "R4");
    // R6: resolve s_b with the opposite outcome, younger dropped
    do_resolve(0, s_b, 1, "R6");
    // R6: unknown sequence ignored
    do_resolve(0, 9999, 0, "R6");
    do_pred(0, 0, "R2");
    do_pred(0, 1, "R2");
    // R5: squash everything younger than s_b
    do_squash(0, s_b, "R5");
    // R5: squash with nothing younger is ignored
    do_squash(0, seqc + 5, "R5");
    // R8: squash and predict to same thread together
    do_pred(0, 1, "R8");
    squash_valid = 1; squash_tid = 0; squash_seq = 16'(s_a);
    commit_valid = 1; commit_tid = 0;
    do_pred(0, 1, "R8");
    // R9: resolve on thread 1 while thread 0 predicts
    resolve_valid = 1; resolve_tid = 1; resolve_seq = 16'(s_c + 2); resolve_taken = 0;
    do_pred(0, 0, "R9");
    // R3: fill thread 1 and push past capacity
    for (int i = 0; i < DP + 3; i++) do_pred(1, i[0], "R3");
    do_commit(1, "R3");
    do_pred(1, 1, "R3");
    // R4: drain thread 0 and commit on empty
    for (int i = 0; i < 6; i++) do_commit(0, "R4");
    do_pred(0, 1, "R4");

    // R7: mixed pseudo-random traffic on both threads
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int op, t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = int'(lfsr[2:0]);
      t  = int'(lfsr[3]);
      case (op)
        0, 1, 2: do_pred(t, lfsr[4], "R7");
        3:       do_commit(t, "R7");
        4:       do_squash(t, seqc - 1 - int'(lfsr[7:5]), "R7");
        5:       do_resolve(t, seqc - 1 - int'(lfsr[7:5]), lfsr[8], "R7");
        default: begin
          pred_valid = 1; pred_tid = ~t[0]; pred_taken = lfsr[9]; pred_seq = 16'(seqc); seqc++;
          commit_valid = 1; commit_tid = t[0];
          step("R7");
        end
      endcase
    end
    finish_run();
  end
endmodule